// File: doc/BRIEF.md
# Self-Triggered Hit Collector with Circulating Read Token

This block gathers hits from many detector channels without any external trigger. Each channel supplies a discriminator level and a digitized pulse-height word. When a channel's discriminator goes high, the block captures the value of a free-running cycle counter in that same cycle. It stores the counter value together with the height in a small queue owned by that channel.

A read token moves around the ring of channels. Channels with empty queues are passed over at no cost. Whichever channel holds data is drained one element at a time. The merged result leaves the block as a valid/ready stream, and each word carries the number of the channel it came from.

Hits that arrive while a channel's queue is full are lost. A per-channel sticky flag marks the loss until a clear pulse removes it.

Top module: `hit_token_collector`

## Requirements
- R1: After reset, out_valid_o is low and every bit of ovf_flag_o is low. The token starts at channel 0 and the time stamp counter is 0. A rising edge sampled at the first clock edge after reset is recorded with stamp 0.
- R2: Only a 0-to-1 transition of a channel's discriminator, seen between two consecutive clock edges, creates an element. A level held high for several cycles produces exactly one element.
- R3: The stamp stored for a hit equals the number of clock edges since reset was released, modulo 2^14. It is taken at the edge that first samples the discriminator high, and 16383 is followed by 0.
- R4: The output word is laid out as out_data_o[32:26] = channel number, [25:12] = stamp and [11:0] = pulse height. The height is the value on the channel's slice of height_i at the capturing edge.
- R5: Each channel keeps its elements in arrival order and holds up to 4 of them.
- R6: A hit on a channel whose queue holds 4 elements, with no read of that channel at the same edge, is discarded and sets that channel's ovf_flag_o bit. The bit stays set until ovf_clr_i is high at an edge. If a discard and a clear fall on the same edge, the bit ends up set.
- R7: The channel offered on the output is the first channel holding data at or after the position following the last channel read, wrapping from 127 to 0. Channels without data are skipped in the same cycle.
- R8: While out_valid_o is high and out_ready_i is low, the next cycle still shows out_valid_o high with the same out_data_o, and no element is removed.
- R9: A hit on a full channel at the same edge as a read of that channel is stored. The read element is removed and the overflow flag stays clear.
- R10: With out_ready_i held high, out_valid_o stays high every cycle until all stored elements have left. This gives one element per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one period is one stamp count |
| rst_n | input | 1 | Asynchronous reset, active low |
| disc_i | input | 128 | Discriminator level, one bit per channel |
| height_i | input | 1536 | Pulse height per channel, channel c on bits [12c+11:12c] |
| ovf_clr_i | input | 1 | Clears all sticky overflow flags |
| out_ready_i | input | 1 | Downstream accepts the offered word |
| out_valid_o | output | 1 | A word is offered |
| out_data_o | output | 33 | {channel, stamp, height} |
| ovf_flag_o | output | 128 | Sticky per-channel overflow flags |

## Verification
Token or queue-pointer state that is wrong shows up on the very next handshake. The offered channel number then breaks the ring order, or the stamp/height pair comes out of order or from the wrong hit. A wrong occupancy count surfaces later. It appears either as an element lost or repeated when a queue drains, which shows as a gap in out_valid_o or an extra word, or as an overflow flag raised one hit early or late. A stamp counter that is wrong is visible in the first element captured after reset and again when the counter wraps.

// File: rtl/htc_pkg.sv
`timescale 1ns/1ps
package htc_pkg;
    localparam int unsigned HTC_CHANNELS = 128;
    localparam int unsigned HTC_TS_BITS  = 14;
    localparam int unsigned HTC_HT_BITS  = 12;
    localparam int unsigned HTC_DEPTH    = 4;

    // position after idx on a ring of n places
    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/hit_fifo.sv
`timescale 1ns/1ps
module hit_fifo #(
    parameter int unsigned W     = 26,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         nonempty_o,
    output logic         drop_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic         full, do_pop, do_push;

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        // a read at the same edge frees the slot the new hit needs
        do_push = push_i && (!full || do_pop);
        drop_o  = push_i && !do_push;
        st_d    = st_q;
        if (do_push) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= wdata_i;
    end

    assign rdata_o    = mem_q[st_q.rp];
    assign nonempty_o = (st_q.cnt != '0);

    p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (st_q.cnt == CW'(DEPTH)));
    p_push_pop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && full) |=> (full && !drop_o || push_i));
endmodule

// File: rtl/token_ring_arb.sv
`timescale 1ns/1ps
module token_ring_arb #(
    parameter int unsigned N  = 128,
    parameter int unsigned IW = 7
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] start_i,
    output logic          any_o,
    output logic [IW-1:0] pick_o
);
    logic [N-1:0]  masked;
    logic [IW-1:0] hi_pick, lo_pick;
    logic          hi_any;

    // two lowest-set-bit searches: one above the token, one over all
    always_comb begin
        masked  = req_i & ({N{1'b1}} << start_i);
        hi_any  = |masked;
        hi_pick = '0;
        lo_pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (masked[k]) hi_pick = IW'(k);
            if (req_i[k])  lo_pick = IW'(k);
        end
        any_o  = |req_i;
        pick_o = hi_any ? hi_pick : lo_pick;
    end
endmodule

// File: rtl/hit_token_collector.sv
`timescale 1ns/1ps
module hit_token_collector
    import htc_pkg::*;
#(
    parameter int unsigned N_CH  = HTC_CHANNELS,
    parameter int unsigned TS_W  = HTC_TS_BITS,
    parameter int unsigned HT_W  = HTC_HT_BITS,
    parameter int unsigned DEPTH = HTC_DEPTH
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_CH-1:0]                    disc_i,
    input  logic [N_CH*HT_W-1:0]               height_i,
    input  logic                               ovf_clr_i,
    input  logic                               out_ready_i,
    output logic                               out_valid_o,
    output logic [$clog2(N_CH)+TS_W+HT_W-1:0]  out_data_o,
    output logic [N_CH-1:0]                    ovf_flag_o
);
    localparam int unsigned CH_W = $clog2(N_CH);
    localparam int unsigned EL_W = TS_W + HT_W;

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic [CH_W-1:0] tok;
        logic [N_CH-1:0] disc;
        logic [N_CH-1:0] ovf;
    } col_st_t;

    col_st_t         st_q, st_d;
    logic [N_CH-1:0] hit, pop, nonempty, drop;
    logic [EL_W-1:0] head [N_CH];
    logic            any, take;
    logic [CH_W-1:0] pick;

    token_ring_arb #(.N(N_CH), .IW(CH_W)) u_arb (
        .req_i   (nonempty),
        .start_i (st_q.tok),
        .any_o   (any),
        .pick_o  (pick)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        hit_fifo #(.W(EL_W), .DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (hit[c]),
            .pop_i      (pop[c]),
            .wdata_i    ({st_q.ts, height_i[c*HT_W +: HT_W]}),
            .rdata_o    (head[c]),
            .nonempty_o (nonempty[c]),
            .drop_o     (drop[c])
        );
    end

    always_comb begin
        take = any && out_ready_i;
        hit  = disc_i & ~st_q.disc;
        pop  = '0;
        if (take) pop[pick] = 1'b1;

        st_d      = st_q;
        st_d.ts   = st_q.ts + 1'b1;
        st_d.disc = disc_i;
        st_d.ovf  = (ovf_clr_i ? '0 : st_q.ovf) | drop;
        // on a stall the token parks on the offered channel so the word holds
        if (any) st_d.tok = take ? CH_W'(ring_next(int'(pick), N_CH)) : pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = any;
    assign out_data_o  = {pick, head[pick]};
    assign ovf_flag_o  = st_q.ovf;

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
    p_pick_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> nonempty[pick]);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_clr_i |=> ((ovf_flag_o & $past(ovf_flag_o)) == $past(ovf_flag_o)));
endmodule

// File: tb/hit_token_collector_test.sv
`timescale 1ns/1ps
module hit_token_collector_test;
    localparam int N  = 128;
    localparam int HW = 12;
    localparam int TM = 16384;
    localparam int W  = 33;

    logic           clk = 1'b0;
    logic           rst_n, ovf_clr, ready;
    logic [N-1:0]   disc;
    logic [N*HW-1:0] height;
    logic           valid;
    logic [W-1:0]   data;
    logic [N-1:0]   ovf;

    int errors = 0, checks = 0, edges = 0, seen = 0, tok_m = 0;
    logic [W-1:0] mq [N][$];
    int           pend_ch [$];
    logic [W-1:0] pend_w [$];

    always #2 clk = ~clk;

    hit_token_collector uut (
        .clk(clk), .rst_n(rst_n), .disc_i(disc), .height_i(height),
        .ovf_clr_i(ovf_clr), .out_ready_i(ready), .out_valid_o(valid),
        .out_data_o(data), .ovf_flag_o(ovf)
    );

    always @(posedge clk) if (rst_n) edges++;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_total();
        int t = 0;
        for (int c = 0; c < N; c++) t += mq[c].size();
        return t;
    endfunction

    // scoreboard: inputs driven at negedge+1, sampled at +1.5, new hits committed at +1.7
    always @(negedge clk) begin : mon
        int  c;
        bit  got;
        #1.5;
        if (rst_n && valid && ready) begin
            got = 0;
            c   = 0;
            for (int k = 0; k < N; k++) begin
                if (!got && mq[(tok_m + k) % N].size() > 0) begin
                    got = 1;
                    c   = (tok_m + k) % N;
                end
            end
            seen++;
            if (!got) chk(0, "R7", "word with nothing stored", longint'(data), 0);
            else begin
                chk(data == mq[c][0], "R4 R5 R7", "output word", longint'(data), longint'(mq[c][0]));
                void'(mq[c].pop_front());
                tok_m = (c + 1) % N;
            end
        end
        #0.2;
        while (pend_ch.size() > 0) begin
            mq[pend_ch.pop_front()].push_back(pend_w.pop_front());
        end
    end

    task automatic arm(int ch, logic [11:0] ht, bit keep);
        height[ch*HW +: HW] = ht;
        disc[ch] = 1'b1;
        if (keep) begin
            pend_ch.push_back(ch);
            pend_w.push_back({7'(ch), 14'(edges % TM), ht});
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse(int ch, logic [11:0] ht, bit keep);
        step(); arm(ch, ht, keep);
        step(); disc[ch] = 1'b0;
    endtask

    task automatic drain(string req);
        int n, s0;
        step();
        n = model_total(); s0 = seen; ready = 1'b1;
        repeat (n) @(negedge clk);
        #1.8;
        chk(seen - s0 == n, req, "elements read", seen - s0, n);
        chk(!valid && model_total() == 0, "R10", "valid low once drained", valid, 0);
        ready = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ready = 1'b0; ovf_clr = 1'b0; disc = '0; height = '0;
        tok_m = 0; edges = 0;
        for (int c = 0; c < N; c++) mq[c].delete();
        repeat (3) @(negedge clk);
        #1;
        chk(!valid, "R1", "valid in reset", valid, 0);
        chk(ovf == '0, "R1", "overflow flags in reset", longint'(ovf[63:0]), 0);
        arm(5, 12'h5a5, 1);
        rst_n = 1'b1;
        step(); disc[5] = 1'b0;
        drain("R1 R3 stamp zero");
    endtask

    task automatic t_edge();
        step(); arm(3, 12'h0f1, 1);
        repeat (3) @(negedge clk);
        #1; disc[3] = 1'b0;
        step(); arm(3, 12'h0f2, 1);
        step(); disc[3] = 1'b0;
        drain("R2");
    endtask

    task automatic t_ring();
        step();
        arm(100, 12'h101, 1); arm(2, 12'h202, 1); arm(127, 12'h303, 1);
        arm(0, 12'h404, 1); arm(64, 12'h505, 1);
        step(); disc = '0;
        step(); arm(2, 12'h606, 1); arm(64, 12'h707, 1);
        step(); disc = '0;
        drain("R7 R10");
    endtask

    task automatic t_stall();
        logic [W-1:0] d0;
        int s0;
        step(); arm(40, 12'h040, 1); arm(41, 12'h041, 1);
        step(); disc = '0;
        step(); d0 = data;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(valid && data == d0, "R8", "held word", longint'(data), longint'(d0));
        end
        s0 = seen;
        ready = 1'b1;
        step(); ready = 1'b0;
        step(); chk(seen - s0 == 1 && valid, "R8", "one read then hold", seen - s0, 1);
        drain("R8");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 6; i++) pulse(20, 12'(i + 1), i < 4);
        step();
        chk(ovf == (N'(1) << 20), "R6", "flag after drops", longint'(ovf[31:0]), 32'h0010_0000);
        ovf_clr = 1'b1;
        step(); ovf_clr = 1'b0;
        chk(ovf == '0, "R6", "flag after clear", longint'(ovf[31:0]), 0);
        step(); arm(20, 12'h777, 0); ovf_clr = 1'b1;
        step(); ovf_clr = 1'b0; disc[20] = 1'b0;
        chk(ovf[20] == 1'b1, "R6", "drop beats clear", ovf[20], 1);
        ovf_clr = 1'b1;
        step(); ovf_clr = 1'b0;
        drain("R5 R6");
    endtask

    task automatic t_same_edge();
        for (int i = 0; i < 4; i++) pulse(7, 12'(16 + i), 1);
        step(); ready = 1'b1; arm(7, 12'h0aa, 1);
        step(); ready = 1'b0; disc[7] = 1'b0;
        chk(ovf == '0, "R9", "no flag on push with read", longint'(ovf[31:0]), 0);
        drain("R9");
    endtask

    task automatic t_wrap();
        do step(); while ((edges % TM) != TM - 2);
        arm(9, 12'h999, 1);
        step(); disc[9] = 1'b0;
        step(); arm(9, 12'h99a, 1);
        step(); disc[9] = 1'b0;
        step();
        chk(valid && data[25:12] == 14'(TM - 2), "R3", "stamp before wrap", longint'(data[25:12]), TM - 2);
        drain("R3");
    endtask

    initial begin
        #(4 * 200000);
        chk(0, "R10", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_edge();
        t_ring();
        t_stall();
        t_overflow();
        t_same_edge();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule